// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a down-counting watchdog controlled through a small write/read register port. Software does not start, feed or unlock it with ordinary data writes. It writes special 16-bit codes into a key register instead: one code starts counting, one refreshes the counter, and one opens the divider and reload registers for a single configuration pass. Once started, the watchdog cannot be stopped by any write.

A free-running slow tick (a one-cycle enable pulse in the system clock domain) drives a selectable divider. Each divider period takes one from a 12-bit counter. When the counter runs out, the block raises a one-cycle reset request, reloads itself and keeps counting. Configuration writes land in a shadow copy first. They reach the counting side only after a two-tick transfer, and a status flag for each register shows while that transfer is under way.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the watchdog is stopped, the request output is low, the divider register reads 0, the reload register reads 0xFFF, the status register reads 0 and the configuration registers are locked.
- R2: Register select values: 0 is the key register (write only, reads 0); 1 is the divider code in bits [2:0]; 2 is the reload value in bits [11:0]; 3 is status, with bit 0 showing a divider update in progress and bit 1 showing a reload update in progress.
- R3: Writing key 0x5555 unlocks the divider and reload registers. While they are locked, writes to them are discarded: the readback does not change and no status flag rises.
- R4: A key write of any value other than 0x5555, including the start and refresh codes, locks the divider and reload registers again.
- R5: Writing key 0xCCCC starts the watchdog. No later write stops it. While it is stopped, ticks never produce a request.
- R6: Divider code c gives a ratio of 4·2^c ticks for c = 0..6, and code 7 also gives 256. The counter takes one step per ratio ticks.
- R7: The reload register keeps only bits [11:0] of a write. Higher bits are ignored.
- R8: An accepted divider or reload write sets its status flag. The flag clears at the second tick pulse after the most recent write to that register, so a rewrite restarts the delay.
- R9: A new reload value is used only by counter loads that happen after its status flag has cleared. A new divider code applies from the tick at which its flag clears.
- R10: Writing key 0xAAAA loads the counter with the active reload value and restarts the divider. The request then follows after exactly ratio × reload ticks.
- R11: When a counter step takes the counter from 1 (or from 0, when the reload is 0) down to zero, the request is high for exactly one clock, in the clock cycle after the tick. The counter reloads and keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow tick enable, one clock wide per tick |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 16 | Combinational read data |
| running | output | 1 | High once the watchdog has been started |
| wdg_req | output | 1 | One-cycle reset request on expiry |

## Verification
The timeout is measured in tick pulses from a start, a refresh or a previous expiry. Several divider codes (0, 1, 3, 6 and 7) and several reload values (0, 1, 2 and 5) are used, and each measured count is compared with ratio × reload. This separates an off-by-one in the divider from one in the counter, and it catches a wrong saturation of code 7. A refresh issued partway through a period and a refresh issued while a reload transfer is still pending show whether the counter loads the active copy or the shadow copy. Locked writes, relocking by foreign keys and attempts to stop the watchdog are each checked through readback and the running output.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int DATA_W = 16;

    localparam logic [DATA_W-1:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [DATA_W-1:0] KEY_START   = 16'hCCCC;

    typedef enum logic [1:0] {
        SEL_KEY    = 2'd0,
        SEL_DIV    = 2'd1,
        SEL_RELOAD = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/wdg_key_dec.sv
module wdg_key_dec
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_val,
    output logic              unlocked,
    output logic              start_hit,
    output logic              refresh_hit
);

    typedef struct packed {
        logic open;
    } key_state_t;

    key_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        start_hit   = 1'b0;
        refresh_hit = 1'b0;
        if (key_wr) begin
            st_d.open   = (key_val == KEY_UNLOCK);
            start_hit   = (key_val == KEY_START);
            refresh_hit = (key_val == KEY_REFRESH);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign unlocked = st_q.open;

    // R4: any foreign key closes the configuration registers
    a_r4_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_val != KEY_UNLOCK) |=> !unlocked);

    // R3: the unlock key opens them
    a_r3_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_val == KEY_UNLOCK) |=> unlocked);

endmodule

// File: rtl/wdg_sync_chan.sv
module wdg_sync_chan #(
    parameter int          W          = 12,
    parameter logic [W-1:0] RST_VAL   = '0,
    parameter int          SYNC_TICKS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] din,
    input  logic         tick,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active,
    output logic         busy
);

    localparam int CW = $clog2(SYNC_TICKS + 1);

    typedef struct packed {
        logic [W-1:0]  shadow;
        logic [W-1:0]  active;
        logic          busy;
        logic [CW-1:0] cnt;
    } chan_t;

    chan_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (wr) begin
            ch_d.shadow = din;
            ch_d.busy   = 1'b1;
            ch_d.cnt    = '0;
        end else if (ch_q.busy && tick) begin
            if (ch_q.cnt == CW'(SYNC_TICKS - 1)) begin
                ch_d.busy   = 1'b0;
                ch_d.active = ch_q.shadow;
                ch_d.cnt    = '0;
            end else begin
                ch_d.cnt = ch_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q.shadow <= RST_VAL;
            ch_q.active <= RST_VAL;
            ch_q.busy   <= 1'b0;
            ch_q.cnt    <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign shadow = ch_q.shadow;
    assign active = ch_q.active;
    assign busy   = ch_q.busy;

    // R8: an accepted write raises the flag
    a_r8_flag_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> busy);

    // R9: the counting copy moves only at the end of a transfer
    a_r9_active_held: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(active));

endmodule

// File: rtl/wdg_divider.sv
module wdg_divider #(
    parameter int CODE_W   = 3,
    parameter int MAX_CODE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clear,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              step
);

    localparam int DIV_W = MAX_CODE + 2;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t dv_d, dv_q;
    logic [DIV_W-1:0] limit;
    int               eff;

    always_comb begin
        eff   = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
        limit = DIV_W'((1 << (eff + 2)) - 1);
        dv_d  = dv_q;
        step  = 1'b0;
        if (clear) begin
            dv_d.cnt = '0;
        end else if (run && tick) begin
            if (dv_q.cnt >= limit) begin
                dv_d.cnt = '0;
                step     = 1'b1;
            end else begin
                dv_d.cnt = dv_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    // R6: a counter step only ever comes from a tick of a running watchdog
    a_r6_step_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (tick && run));

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdg_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int CODE_W     = 3,
    parameter int MAX_CODE   = 6,
    parameter int SYNC_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              running,
    output logic              wdg_req
);

    localparam logic [CNT_W-1:0] RELOAD_RST = '1;

    typedef struct packed {
        logic             running;
        logic [CNT_W-1:0] cnt;
        logic             req;
    } core_t;

    core_t core_d, core_q;

    logic              key_wr, div_wr, rld_wr;
    logic              unlocked, start_hit, refresh_hit, reload_evt;
    logic              step;
    logic [CODE_W-1:0] div_shadow, div_act;
    logic [CNT_W-1:0]  rld_shadow, rld_act;
    logic              div_busy, rld_busy;

    assign key_wr = wr_en && (wr_sel == SEL_KEY);
    assign div_wr = wr_en && (wr_sel == SEL_DIV)    && unlocked;
    assign rld_wr = wr_en && (wr_sel == SEL_RELOAD) && unlocked;

    wdg_key_dec u_key (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_wr      (key_wr),
        .key_val     (wr_data),
        .unlocked    (unlocked),
        .start_hit   (start_hit),
        .refresh_hit (refresh_hit)
    );

    wdg_sync_chan #(
        .W          (CODE_W),
        .RST_VAL    ('0),
        .SYNC_TICKS (SYNC_TICKS)
    ) u_div_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (div_wr),
        .din    (wr_data[CODE_W-1:0]),
        .tick   (tick),
        .shadow (div_shadow),
        .active (div_act),
        .busy   (div_busy)
    );

    wdg_sync_chan #(
        .W          (CNT_W),
        .RST_VAL    (RELOAD_RST),
        .SYNC_TICKS (SYNC_TICKS)
    ) u_rld_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (rld_wr),
        .din    (wr_data[CNT_W-1:0]),
        .tick   (tick),
        .shadow (rld_shadow),
        .active (rld_act),
        .busy   (rld_busy)
    );

    assign reload_evt = start_hit || refresh_hit;

    wdg_divider #(
        .CODE_W   (CODE_W),
        .MAX_CODE (MAX_CODE)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (core_q.running),
        .clear (reload_evt),
        .tick  (tick),
        .code  (div_act),
        .step  (step)
    );

    always_comb begin
        core_d     = core_q;
        core_d.req = 1'b0;
        if (start_hit) core_d.running = 1'b1;
        if (reload_evt) begin
            core_d.cnt = rld_act;
        end else if (core_q.running && step) begin
            if (core_q.cnt <= CNT_W'(1)) begin
                core_d.cnt = rld_act;
                core_d.req = 1'b1;
            end else begin
                core_d.cnt = core_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q.running <= 1'b0;
            core_q.cnt     <= RELOAD_RST;
            core_q.req     <= 1'b0;
        end else begin
            core_q <= core_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_DIV:    rd_data[CODE_W-1:0] = div_shadow;
            SEL_RELOAD: rd_data[CNT_W-1:0]  = rld_shadow;
            SEL_STATUS: rd_data[1:0]        = {rld_busy, div_busy};
            default:    rd_data = '0;
        endcase
    end

    assign running = core_q.running;
    assign wdg_req = core_q.req;

    // R5: once started, nothing stops the watchdog
    a_r5_sticky_run: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    // R11: the request is a single clock wide
    a_r11_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_req |=> !wdg_req);

    // R11: a request comes only from a running watchdog
    a_r11_req_running: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_req |-> running);

    // R10: a refresh loads the counter from the counting-side reload copy
    a_r10_refresh_load: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wr_data == KEY_REFRESH) |=> (core_q.cnt == $past(rld_act)));

    // R3: locked writes leave the readback untouched
    a_r3_locked_div: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(div_shadow));

endmodule

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        running;
    logic        wdg_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    keyed_watchdog u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .running (running),
        .wdg_req (wdg_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd_check(input logic [1:0] sel, input int exp, input string tag);
        rd_sel = sel;
        #1;
        check(int'(rd_data) == exp, tag, int'(rd_data), exp);
    endtask

    task automatic pulse(output bit seen);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        seen = wdg_req;
    endtask

    task automatic ticks_to_req(output int n);
        bit seen;
        n = 0;
        do begin
            pulse(seen);
            n++;
        end while (!seen && n < 3000);
    endtask

    task automatic set_cfg(input int code, input int rl);
        bit seen;
        wr(2'd0, 16'hAAAA);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'(code));
        wr(2'd2, 16'(rl));
        pulse(seen);
        pulse(seen);
        wr(2'd0, 16'hAAAA);
    endtask

    task automatic t_reset();
        check(running == 1'b0, "R1 running", running, 0);
        check(wdg_req == 1'b0, "R1 req", wdg_req, 0);
        rd_check(2'd1, 0, "R1 divider reset");
        rd_check(2'd2, 'hFFF, "R1 reload reset");
        rd_check(2'd3, 0, "R1 status reset");
        rd_check(2'd0, 0, "R2 key reads zero");
    endtask

    task automatic t_locked();
        bit seen;
        int hits = 0;
        wr(2'd1, 16'd3);
        wr(2'd2, 16'h123);
        rd_check(2'd1, 0, "R3 locked divider write");
        rd_check(2'd2, 'hFFF, "R3 locked reload write");
        rd_check(2'd3, 0, "R3 no flag when locked");
        for (int i = 0; i < 10; i++) begin
            pulse(seen);
            if (seen) hits++;
        end
        check(hits == 0, "R5 no request while stopped", hits, 0);
    endtask

    task automatic t_unlock();
        bit seen;
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'h1005);
        rd_check(2'd2, 'h005, "R7 upper reload bits dropped");
        rd_check(2'd3, 2, "R8 reload flag set");
        pulse(seen);
        rd_check(2'd3, 2, "R8 flag after one tick");
        pulse(seen);
        rd_check(2'd3, 0, "R8 flag after two ticks");
        wr(2'd1, 16'd1);
        rd_check(2'd1, 1, "R3 divider write accepted");
        rd_check(2'd3, 1, "R8 divider flag set");
        pulse(seen);
        wr(2'd1, 16'd1);
        pulse(seen);
        rd_check(2'd3, 1, "R8 rewrite restarts delay");
        pulse(seen);
        rd_check(2'd3, 0, "R8 divider flag cleared");
    endtask

    task automatic t_relock();
        wr(2'd0, 16'h1234);
        wr(2'd1, 16'd5);
        rd_check(2'd1, 1, "R4 foreign key relocks");
    endtask

    task automatic t_start();
        int n;
        wr(2'd0, 16'hCCCC);
        check(running == 1'b1, "R5 start key", running, 1);
        ticks_to_req(n);
        check(n == 40, "R6 R11 first timeout ratio 8 reload 5", n, 40);
        @(negedge clk);
        check(wdg_req == 1'b0, "R11 request one clock", wdg_req, 0);
        ticks_to_req(n);
        check(n == 40, "R11 keeps running after expiry", n, 40);
    endtask

    task automatic t_nostop();
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'hAAAA);
        check(running == 1'b1, "R5 cannot be stopped", running, 1);
    endtask

    task automatic t_refresh();
        bit seen;
        int n;
        for (int i = 0; i < 20; i++) pulse(seen);
        wr(2'd0, 16'hAAAA);
        ticks_to_req(n);
        check(n == 40, "R10 refresh restarts period", n, 40);
        wr(2'd1, 16'd2);
        rd_check(2'd1, 1, "R4 refresh key locks");
    endtask

    task automatic t_pending();
        int n;
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'd2);
        wr(2'd0, 16'hAAAA);
        ticks_to_req(n);
        check(n == 40, "R9 pending reload not used", n, 40);
        wr(2'd0, 16'hAAAA);
        ticks_to_req(n);
        check(n == 16, "R9 transferred reload used", n, 16);
    endtask

    task automatic t_ratios();
        int n;
        set_cfg(0, 1);
        ticks_to_req(n);
        check(n == 4, "R6 code 0", n, 4);
        set_cfg(3, 1);
        ticks_to_req(n);
        check(n == 32, "R6 code 3", n, 32);
        set_cfg(6, 1);
        ticks_to_req(n);
        check(n == 256, "R6 code 6", n, 256);
        set_cfg(7, 1);
        ticks_to_req(n);
        check(n == 256, "R6 code 7 saturates", n, 256);
        set_cfg(0, 0);
        ticks_to_req(n);
        check(n == 4, "R11 reload zero", n, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked();
        t_unlock();
        t_relock();
        t_start();
        t_nostop();
        t_refresh();
        t_pending();
        t_ratios();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule